// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the processor-side register file of a four-channel DMA controller. A byte-wide bus reaches it. For each channel it keeps a 16-bit start address and a 16-bit transfer count. It also keeps a per-channel enable mask, a per-channel mode field, a command byte and a software request bit. The programmed base values, masks, modes and command are driven out to a separate transfer engine. The engine returns its running address and count, and it signals terminal count and pending requests.

Each 16-bit register is reached through a single byte port. One shared byte-pointer flip-flop selects which half an access touches. It flips after every address or count access, read or write. A dedicated command port forces it back to the low half. The byte ports above the channel ports hold one-shot commands: pointer clear, master clear, unmask all, load all masks. They also hold the single mask, mode, request and command/status ports. These ports sit at fixed offsets, because the software that drives the block depends on them.

Top module: `dmac_prog_regs`

## Requirements
- R1: After reset every mask bit is 1, every mode field, the command byte and all software requests are 0, every base and current register is 0, the byte pointer selects the low half, and a status read returns 0x00 when no engine request is pending.
- R2: A write to port 2*ch loads one byte of that channel's address, and a write to port 2*ch+1 loads one byte of its count. The low byte is loaded when the pointer is low and the high byte when it is high. Each write loads both the base copy and the current copy of that byte, and base values appear on the exported base outputs.
- R3: The pointer flips after every read or write of an address or count port. Any write to port 0x0C returns it to low. A write to port 0x0D also returns it to low.
- R4: A read of an address or count port returns the current copy of that register, low byte when the pointer is low and high byte when it is high.
- R5: A write to port 0x0A selects channel data[1:0] and sets its mask bit to data[2] (1 = disabled). The other mask bits are left unchanged.
- R6: A write to port 0x0B selects channel data[1:0] and stores data[7:2] as its 6-bit mode. Within that field, bit 2 (data bit 4) is auto-initialise, bits [1:0] give direction (01 device-to-memory, 10 memory-to-device), and bits [5:4] give the transfer type (01 single, 11 cascade).
- R7: A write to port 0x0D (master clear) sets all mask bits, zeroes all modes, the command byte, the software requests and the terminal-count flags, and resets the pointer. Address and count registers are not affected.
- R8: A write to port 0x0E clears all mask bits. A write to port 0x0F loads mask bit ch from data bit ch.
- R9: A read of port 0x08 returns terminal-count flags in bits [3:0] and pending requests (engine request OR software request) in bits [7:4]. The read clears the terminal-count flags, except that a flag raised by the engine in the same cycle stays set.
- R10: A terminal-count pulse on a channel whose mode has auto-initialise set copies that channel's base address and base count into its current registers at the next edge. Without auto-initialise the current registers are kept.
- R11: A write to port 0x08 stores the command byte. A write to port 0x09 selects channel data[1:0] and sets its software request to data[2].
- R12: An engine update loads the current address and count of the selected channel and never touches the base copies. A processor write to one of that channel's ports in the same cycle takes priority for the register it targets, in both copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte port number |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is strobed |
| eng_upd_valid | input | 1 | Engine writes back running address and count |
| eng_upd_ch | input | 2 | Channel for the engine write-back |
| eng_upd_addr | input | 16 | Running address from the engine |
| eng_upd_cnt | input | 16 | Remaining count (minus-one form) from the engine |
| eng_tc | input | 4 | Terminal-count pulses, one per channel |
| eng_req | input | 4 | Pending hardware requests, one per channel |
| base_addr_o | output | 64 | Base addresses, channel ch at [16*ch +: 16] |
| base_cnt_o | output | 64 | Base counts, channel ch at [16*ch +: 16] |
| mask_o | output | 4 | Channel masks, 1 = disabled |
| mode_o | output | 24 | Mode fields, channel ch at [6*ch +: 6] |
| cmd_o | output | 8 | Command byte |
| sw_req_o | output | 4 | Software request bits |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions: a status read that meets a fresh terminal-count pulse, and a processor byte write that meets an engine write-back to the same channel. The bench raises the engine input on the same negative clock edge on which it strobes the bus access, so both land on one rising edge. It then reads the flags and both register halves back through the byte ports. The pointer state is exposed the same way. A read followed by a write proves that reads also flip the pointer, and a lone byte write before a master clear shows that the clear reset it.

// File: rtl/dmac_prog_pkg.sv
package dmac_prog_pkg;
   localparam int unsigned PORT_W = 4;
   localparam logic [PORT_W-1:0] PORT_STAT    = 4'h8;
   localparam logic [PORT_W-1:0] PORT_REQ     = 4'h9;
   localparam logic [PORT_W-1:0] PORT_SMASK   = 4'hA;
   localparam logic [PORT_W-1:0] PORT_MODE    = 4'hB;
   localparam logic [PORT_W-1:0] PORT_CLRPTR  = 4'hC;
   localparam logic [PORT_W-1:0] PORT_MCLR    = 4'hD;
   localparam logic [PORT_W-1:0] PORT_CLRMASK = 4'hE;
   localparam logic [PORT_W-1:0] PORT_ALLMASK = 4'hF;
   // index of the auto-initialise flag inside the stored mode field
   localparam int unsigned MODE_AUTO_BIT = 2;
endpackage

// File: rtl/dmac_ptr_ff.sv
module dmac_ptr_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic toggle,
   input  logic clear,
   output logic hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi <= 1'b0;
      else if (clear)  hi <= 1'b0;
      else if (toggle) hi <= ~hi;
   end

   p_ptr_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (toggle && !clear) |=> (hi != $past(hi)))
      else $error("pointer did not flip");
   p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !hi)
      else $error("pointer not cleared");
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs #(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_addr,
   input  logic             wr_cnt,
   input  logic             hi_sel,
   input  logic [BUS_W-1:0] wdata,
   input  logic             reload,
   input  logic             upd,
   input  logic [REG_W-1:0] upd_addr,
   input  logic [REG_W-1:0] upd_cnt,
   output logic [REG_W-1:0] base_addr,
   output logic [REG_W-1:0] base_cnt,
   output logic [REG_W-1:0] cur_addr,
   output logic [REG_W-1:0] cur_cnt
);
   function automatic logic [REG_W-1:0] put_half(input logic [REG_W-1:0] old,
                                                  input logic [BUS_W-1:0] b,
                                                  input logic             h);
      logic [REG_W-1:0] r;
      r = old;
      if (h) r[REG_W-1:BUS_W] = b;
      else   r[BUS_W-1:0]     = b;
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         cur_addr  <= '0;
      end else if (wr_addr) begin
         base_addr <= put_half(base_addr, wdata, hi_sel);
         cur_addr  <= put_half(cur_addr, wdata, hi_sel);
      end else if (reload) begin
         cur_addr  <= base_addr;
      end else if (upd) begin
         cur_addr  <= upd_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_cnt <= '0;
         cur_cnt  <= '0;
      end else if (wr_cnt) begin
         base_cnt <= put_half(base_cnt, wdata, hi_sel);
         cur_cnt  <= put_half(cur_cnt, wdata, hi_sel);
      end else if (reload) begin
         cur_cnt  <= base_cnt;
      end else if (upd) begin
         cur_cnt  <= upd_cnt;
      end
   end

   p_base_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_addr && !wr_cnt) |=> ($stable(base_addr) && $stable(base_cnt)))
      else $error("base copy changed without a processor write");
   p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !wr_addr) |=> (cur_addr == $past(base_addr)))
      else $error("auto-init reload missed");
   p_upd_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !reload && !wr_cnt) |=> (cur_cnt == $past(upd_cnt)))
      else $error("engine count update lost");
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned BUS_W  = 8,
   localparam int unsigned MODE_W = BUS_W - 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [BUS_W-1:0]         wdata,
   input  logic                     wr_cmd,
   input  logic                     wr_req,
   input  logic                     wr_smask,
   input  logic                     wr_mode,
   input  logic                     wr_mclr,
   input  logic                     wr_clrmask,
   input  logic                     wr_allmask,
   input  logic                     rd_stat,
   input  logic [NUM_CH-1:0]        eng_tc,
   input  logic [NUM_CH-1:0]        eng_req,
   output logic [NUM_CH-1:0]        mask,
   output logic [NUM_CH*MODE_W-1:0] mode,
   output logic [BUS_W-1:0]         cmd,
   output logic [NUM_CH-1:0]        sw_req,
   output logic [BUS_W-1:0]         status
);
   logic [NUM_CH-1:0] tc_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [1:0] SEL = 2'(c);
      logic             m_q;
      logic             r_q;
      logic [MODE_W-1:0] md_q;
      wire              hit = (wdata[1:0] == SEL);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                m_q <= 1'b1;
         else if (wr_mclr)          m_q <= 1'b1;
         else if (wr_clrmask)       m_q <= 1'b0;
         else if (wr_allmask)       m_q <= wdata[c];
         else if (wr_smask && hit)  m_q <= wdata[2];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            md_q <= '0;
            r_q  <= 1'b0;
         end else if (wr_mclr) begin
            md_q <= '0;
            r_q  <= 1'b0;
         end else begin
            if (wr_mode && hit) md_q <= wdata[BUS_W-1:2];
            if (wr_req && hit)  r_q  <= wdata[2];
         end
      end

      assign mask[c]                 = m_q;
      assign sw_req[c]               = r_q;
      assign mode[c*MODE_W +: MODE_W] = md_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd  <= '0;
         tc_q <= '0;
      end else if (wr_mclr) begin
         cmd  <= '0;
         tc_q <= '0;
      end else begin
         if (wr_cmd) cmd <= wdata;
         tc_q <= (rd_stat ? '0 : tc_q) | eng_tc;
      end
   end

   always_comb begin
      status               = '0;
      status[NUM_CH-1:0]   = tc_q;
      status[4 +: NUM_CH]  = eng_req | sw_req;
   end

   p_mclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mclr |=> ((&mask) && (cmd == '0) && (sw_req == '0) && (mode == '0)))
      else $error("master clear incomplete");
   p_clrmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clrmask && !wr_mclr) |=> (mask == '0))
      else $error("clear-mask left a bit set");
   p_tc_rdclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && eng_tc == '0) |=> (status[NUM_CH-1:0] == '0))
      else $error("status read did not clear flags");
   p_tc_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_mclr && eng_tc != '0) |=> ((status[NUM_CH-1:0] & $past(eng_tc)) == $past(eng_tc)))
      else $error("terminal count flag lost");
   p_smask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_smask && wdata[1:0] == 2'd0) |=> (mask[0] == $past(wdata[2])))
      else $error("single mask write missed");
endmodule

// File: rtl/dmac_prog_regs.sv
module dmac_prog_regs
   import dmac_prog_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned REG_W  = 16,
   localparam int unsigned MODE_W = BUS_W - 2,
   localparam int unsigned CH_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_cs,
   input  logic                     bus_we,
   input  logic [PORT_W-1:0]        bus_addr,
   input  logic [BUS_W-1:0]         bus_wdata,
   output logic [BUS_W-1:0]         bus_rdata,
   input  logic                     eng_upd_valid,
   input  logic [CH_W-1:0]          eng_upd_ch,
   input  logic [REG_W-1:0]         eng_upd_addr,
   input  logic [REG_W-1:0]         eng_upd_cnt,
   input  logic [NUM_CH-1:0]        eng_tc,
   input  logic [NUM_CH-1:0]        eng_req,
   output logic [NUM_CH*REG_W-1:0]  base_addr_o,
   output logic [NUM_CH*REG_W-1:0]  base_cnt_o,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [NUM_CH*MODE_W-1:0] mode_o,
   output logic [BUS_W-1:0]         cmd_o,
   output logic [NUM_CH-1:0]        sw_req_o
);
   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must lie in 1..4");
   end
   if (BUS_W < 8 || REG_W != 2 * BUS_W) begin : g_bad_w
      $error("BUS_W must be at least 8 and REG_W twice BUS_W");
   end

   wire bus_wr   = bus_cs && bus_we;
   wire bus_rd   = bus_cs && !bus_we;
   wire chan_hit = bus_cs && !bus_addr[3] && ({1'b0, bus_addr[2:1]} < 3'(NUM_CH));
   wire wr_clrp  = bus_wr && (bus_addr == PORT_CLRPTR);
   wire wr_mclr  = bus_wr && (bus_addr == PORT_MCLR);
   wire rd_stat  = bus_rd && (bus_addr == PORT_STAT);

   logic ptr_hi;
   logic [BUS_W-1:0] status;
   logic [REG_W-1:0] cur_addr_w [NUM_CH];
   logic [REG_W-1:0] cur_cnt_w  [NUM_CH];

   dmac_ptr_ff u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .toggle (chan_hit),
      .clear  (wr_clrp || wr_mclr),
      .hi     (ptr_hi)
   );

   dmac_ctrl_regs #(.NUM_CH(NUM_CH), .BUS_W(BUS_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata      (bus_wdata),
      .wr_cmd     (bus_wr && bus_addr == PORT_STAT),
      .wr_req     (bus_wr && bus_addr == PORT_REQ),
      .wr_smask   (bus_wr && bus_addr == PORT_SMASK),
      .wr_mode    (bus_wr && bus_addr == PORT_MODE),
      .wr_mclr    (wr_mclr),
      .wr_clrmask (bus_wr && bus_addr == PORT_CLRMASK),
      .wr_allmask (bus_wr && bus_addr == PORT_ALLMASK),
      .rd_stat    (rd_stat),
      .eng_tc     (eng_tc),
      .eng_req    (eng_req),
      .mask       (mask_o),
      .mode       (mode_o),
      .cmd        (cmd_o),
      .sw_req     (sw_req_o),
      .status     (status)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      localparam logic [CH_W-1:0] SEL = CH_W'(c);
      wire sel = bus_wr && !bus_addr[3] && (bus_addr[2:1] == SEL);

      dmac_chan_regs #(.BUS_W(BUS_W), .REG_W(REG_W)) u_regs (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_addr   (sel && !bus_addr[0]),
         .wr_cnt    (sel && bus_addr[0]),
         .hi_sel    (ptr_hi),
         .wdata     (bus_wdata),
         .reload    (eng_tc[c] && mode_o[c*MODE_W + MODE_AUTO_BIT]),
         .upd       (eng_upd_valid && eng_upd_ch == SEL),
         .upd_addr  (eng_upd_addr),
         .upd_cnt   (eng_upd_cnt),
         .base_addr (base_addr_o[c*REG_W +: REG_W]),
         .base_cnt  (base_cnt_o[c*REG_W +: REG_W]),
         .cur_addr  (cur_addr_w[c]),
         .cur_cnt   (cur_cnt_w[c])
      );
   end

   always_comb begin
      logic [REG_W-1:0] word;
      word      = '0;
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == PORT_STAT) bus_rdata = status;
         for (int c = 0; c < NUM_CH; c++) begin
            if (!bus_addr[3] && bus_addr[2:1] == CH_W'(c)) begin
               word      = bus_addr[0] ? cur_cnt_w[c] : cur_addr_w[c];
               bus_rdata = ptr_hi ? word[REG_W-1:BUS_W] : word[BUS_W-1:0];
            end
         end
      end
   end

   p_idle_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0))
      else $error("read data driven without a read");
   p_mclr_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mclr |=> (mask_o == '1))
      else $error("master clear left a channel enabled");
endmodule

// File: tb/dmac_prog_regs_bench.sv
module dmac_prog_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        eng_upd_valid = 1'b0;
   logic [1:0]  eng_upd_ch = '0;
   logic [15:0] eng_upd_addr = '0, eng_upd_cnt = '0;
   logic [3:0]  eng_tc = '0, eng_req = '0;
   logic [63:0] base_addr_o, base_cnt_o;
   logic [3:0]  mask_o, sw_req_o;
   logic [23:0] mode_o;
   logic [7:0]  cmd_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dmac_prog_regs u_dmac_prog_regs (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_upd_valid(eng_upd_valid), .eng_upd_ch(eng_upd_ch),
      .eng_upd_addr(eng_upd_addr), .eng_upd_cnt(eng_upd_cnt),
      .eng_tc(eng_tc), .eng_req(eng_req),
      .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o), .mask_o(mask_o),
      .mode_o(mode_o), .cmd_o(cmd_o), .sw_req_o(sw_req_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_cs = 1'b0;
   endtask

   task automatic tc_pulse(input logic [3:0] v);
      @(negedge clk); eng_tc = v;
      @(negedge clk); eng_tc = '0;
   endtask

   task automatic eng_update(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] n);
      @(negedge clk);
      eng_upd_valid = 1'b1; eng_upd_ch = ch; eng_upd_addr = a; eng_upd_cnt = n;
      @(negedge clk);
      eng_upd_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 mask", mask_o, 4'hF);
      check("R1 mode", mode_o, 24'h0);
      check("R1 cmd", cmd_o, 8'h00);
      check("R1 base addr", base_addr_o[31:0], 32'h0);
      bus_rd(4'h8, d);
      check("R1 status", d, 8'h00);
   endtask

   task automatic t_write16;
      bus_wr(4'hC, 8'h00);
      bus_wr(4'h2, 8'h34);
      bus_wr(4'h2, 8'h12);
      check("R2 ch1 base addr", base_addr_o[31:16], 16'h1234);
      bus_wr(4'h5, 8'hCD);
      bus_wr(4'h5, 8'hAB);
      check("R2 ch2 base count", base_cnt_o[47:32], 16'hABCD);
   endtask

   task automatic t_readback;
      logic [7:0] lo, hi;
      bus_rd(4'h2, lo); bus_rd(4'h2, hi);
      check("R4 ch1 addr read", {hi, lo}, 16'h1234);
      bus_rd(4'h5, lo); bus_rd(4'h5, hi);
      check("R4 ch2 count read", {hi, lo}, 16'hABCD);
   endtask

   task automatic t_pointer;
      logic [7:0] d;
      bus_wr(4'h0, 8'h55);
      bus_wr(4'hC, 8'hFF);
      bus_wr(4'h0, 8'h66);
      bus_wr(4'h0, 8'h77);
      check("R3 clear pointer", base_addr_o[15:0], 16'h7766);
      bus_rd(4'h0, d);
      check("R3 read low", d, 8'h66);
      bus_wr(4'h0, 8'h88);
      check("R3 read flips pointer", base_addr_o[15:0], 16'h8866);
   endtask

   task automatic t_masks;
      bus_wr(4'hE, 8'h00);
      check("R8 clear masks", mask_o, 4'h0);
      bus_wr(4'hA, 8'h05);
      check("R5 mask ch1", mask_o, 4'h2);
      bus_wr(4'hA, 8'h01);
      check("R5 unmask ch1", mask_o, 4'h0);
      bus_wr(4'hA, 8'h07);
      check("R5 mask ch3", mask_o, 4'h8);
      bus_wr(4'hF, 8'hA5);
      check("R8 load all masks", mask_o, 4'h5);
   endtask

   task automatic t_mode;
      bus_wr(4'hB, 8'h5A);
      check("R6 mode ch2", mode_o, 24'h016000);
   endtask

   task automatic t_status;
      logic [7:0] d;
      eng_req = 4'b0010;
      tc_pulse(4'b1000);
      bus_rd(4'h8, d);
      check("R9 status flags", d, 8'h28);
      bus_rd(4'h8, d);
      check("R9 flags cleared by read", d, 8'h20);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = 4'h8; eng_tc = 4'b0001;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_cs = 1'b0; eng_tc = '0;
      check("R9 read before set", d, 8'h20);
      bus_rd(4'h8, d);
      check("R9 set beats clear", d, 8'h21);
      bus_rd(4'h8, d);
      check("R9 cleared again", d, 8'h20);
   endtask

   task automatic t_cmd_req;
      logic [7:0] d;
      bus_wr(4'h8, 8'h3C);
      check("R11 command", cmd_o, 8'h3C);
      bus_wr(4'h9, 8'h04);
      check("R11 sw request", sw_req_o, 4'h1);
      bus_rd(4'h8, d);
      check("R11 R9 pending merge", d, 8'h30);
      bus_wr(4'h9, 8'h00);
      check("R11 sw request clear", sw_req_o, 4'h0);
   endtask

   task automatic t_engine;
      logic [7:0] lo, hi;
      eng_update(2'd1, 16'h2000, 16'h00FF);
      bus_rd(4'h3, lo); bus_rd(4'h3, hi);
      check("R12 engine count", {hi, lo}, 16'h00FF);
      bus_rd(4'h2, lo); bus_rd(4'h2, hi);
      check("R12 engine addr", {hi, lo}, 16'h2000);
      check("R12 base untouched", base_addr_o[31:16], 16'h1234);
   endtask

   task automatic t_autoinit;
      logic [7:0] lo, hi;
      bus_wr(4'hB, 8'h51);
      check("R6 mode ch1", mode_o[11:6], 6'h14);
      tc_pulse(4'b0010);
      bus_rd(4'h2, lo); bus_rd(4'h2, hi);
      check("R10 reload addr", {hi, lo}, 16'h1234);
      bus_rd(4'h3, lo); bus_rd(4'h3, hi);
      check("R10 reload count", {hi, lo}, 16'h0000);
      eng_update(2'd0, 16'h4444, 16'h0001);
      tc_pulse(4'b0001);
      bus_rd(4'h0, lo); bus_rd(4'h0, hi);
      check("R10 no reload without auto-init", {hi, lo}, 16'h4444);
   endtask

   task automatic t_priority;
      logic [7:0] lo, hi;
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 8'h99;
      eng_upd_valid = 1'b1; eng_upd_ch = 2'd0; eng_upd_addr = 16'hBEEF; eng_upd_cnt = 16'h0042;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0; eng_upd_valid = 1'b0;
      bus_wr(4'hC, 8'h00);
      bus_rd(4'h0, lo); bus_rd(4'h0, hi);
      check("R12 processor wins addr", {hi, lo}, 16'h4499);
      bus_rd(4'h1, lo); bus_rd(4'h1, hi);
      check("R12 engine count same cycle", {hi, lo}, 16'h0042);
      check("R12 base low byte", base_addr_o[15:0], 16'h8899);
   endtask

   task automatic t_mclr;
      logic [7:0] d;
      bus_wr(4'h0, 8'h12);
      bus_wr(4'hD, 8'h00);
      check("R7 masks set", mask_o, 4'hF);
      check("R7 modes zero", mode_o, 24'h0);
      check("R7 command zero", cmd_o, 8'h00);
      bus_rd(4'h8, d);
      check("R7 flags cleared", d, 8'h20);
      check("R7 address kept", base_addr_o[31:16], 16'h1234);
      bus_wr(4'h6, 8'h11);
      bus_wr(4'h6, 8'h22);
      check("R7 pointer reset", base_addr_o[63:48], 16'h2211);
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_write16;
      t_readback;
      t_pointer;
      t_masks;
      t_mode;
      t_status;
      t_cmd_req;
      t_engine;
      t_autoinit;
      t_priority;
      t_mclr;
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule